// File: doc/BRIEF.md
# Board System Control Port Block

This block is a byte-wide register file that sits on a 16-bit I/O port space of a PC-style board controller. A host issues single-cycle read or write strobes with a port address. The block responds to one special port (0x92) that controls a CPU soft reset and the processor byte order. It also responds to a sparse bank of ports from 0x800 to 0x850 that hold board identification constants, status values and a few control bits.

Writes to the control ports drive level outputs: a disk-activity lamp, a 4-bit system control field and an I/O map mode bit. Another block uses the map mode bit to reshape its address translation. Writes to the two NVRAM lock ports do not store anything. Each such write produces a one-cycle toggle pulse to the NVRAM. Read data is registered. A sticky flag records any write to a port the block does not accept, so integration errors can be seen.

Top module: `sysctl_ports`

## Requirements
- R1: While reset is low, and after it is released, every output is 0: soft reset, byte order, lamp, both pulses, system control, map mode, error flag and read data.
- R2: A write to port 0x92 loads the soft-reset output from data bit 0 and the little-endian output from data bit 1. A read of 0x92 returns 0x00.
- R3: Reads return fixed constants: 0x800 gives 0xEF, 0x802 gives 0xAD, 0x803 gives 0xE0, 0x80C gives 0x3C, 0x810 gives 0x39 and 0x823 gives 0x03.
- R4: Writes to 0x800, 0x802 and 0x803 change no output and do not set the error flag, and these ports still read back their constants.
- R5: A write to 0x808 sets the lamp output to data bit 0.
- R6: Any write to 0x810 raises the lock-1 pulse for exactly one cycle, and any write to 0x812 does the same for the lock-2 pulse, whatever the data.
- R7: A write to 0x81C stores data bits 3:0 on the system control output, and data bits 7:4 are dropped. A read of 0x81C returns the stored value zero-extended.
- R8: A write to 0x850 stores data bit 0 as the map mode. A read of 0x850 returns it zero-extended.
- R9: Port 0x818 reads 0x00. A write to 0x814 is accepted with no effect, and a read of 0x814 or 0x812 gives 0xFF.
- R10: A read of any port not named in R2, R3, R7, R8 or R9 returns 0xFF.
- R11: A write to a port outside the accepted set sets the error flag, which stays set until reset. Such a write changes no other output. The accepted set is 0x92, 0x800, 0x802, 0x803, 0x808, 0x810, 0x812, 0x814, 0x81C and 0x850.
- R12: Read data appears on the clock edge that samples the read strobe, and it holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 16 | Port address |
| io_rd | input | 1 | Read strobe |
| io_wr | input | 1 | Write strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Registered read data |
| soft_rst | output | 1 | CPU soft-reset request |
| le_mode | output | 1 | Little-endian flag |
| disk_lamp | output | 1 | Disk-activity lamp |
| nvl1_pulse | output | 1 | NVRAM lock-1 toggle pulse |
| nvl2_pulse | output | 1 | NVRAM lock-2 toggle pulse |
| sys_ctrl | output | 4 | System control field |
| map_mode | output | 1 | I/O map mode |
| wr_err | output | 1 | Sticky unmapped-write flag |

## Verification
Every stored bit drives an output directly, so a wrong latch or a wrong mask shows on the same edge that samples the write. A read back one edge later shows it a second time. A decode error is different: it only shows when the bad port is accessed. Such an error can show as a wrong constant, a stray 0xFF, a pulse that never fires, or an error flag that should not be set. The bench therefore walks every named port with both strobes and random data, and it also reads and writes random addresses.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;
    localparam int CTRL_W = 4;

    localparam logic [DATA_W-1:0] RD_UNMAPPED = '1;
    localparam logic [DATA_W-1:0] ID_CPUCFG   = 8'hEF;
    localparam logic [DATA_W-1:0] ID_FEAT     = 8'hAD;
    localparam logic [DATA_W-1:0] ID_STAT     = 8'hE0;
    localparam logic [DATA_W-1:0] ID_EQUIP    = 8'h3C;
    localparam logic [DATA_W-1:0] ID_EXTFEAT  = 8'h39;
    localparam logic [DATA_W-1:0] ID_CACHE    = 8'h03;

    typedef enum logic [3:0] {
        SEL_P92, SEL_CPUCFG, SEL_FEAT, SEL_STAT, SEL_EQUIP, SEL_LAMP,
        SEL_NVL1, SEL_NVL2, SEL_CINV, SEL_KEY, SEL_SYSCTL, SEL_CACHE,
        SEL_MAP, SEL_NONE
    } sel_e;

    typedef struct packed {
        logic              soft_rst;
        logic              le_mode;
        logic              lamp;
        logic              nvl1;
        logic              nvl2;
        logic [CTRL_W-1:0] sysctl;
        logic              map;
        logic              err;
        logic [DATA_W-1:0] rdata;
    } state_t;
endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
    import sysctl_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output sel_e              sel,
    output logic              wr_ok
);
    always_comb begin
        case (addr)
            16'h0092: sel = SEL_P92;
            16'h0800: sel = SEL_CPUCFG;
            16'h0802: sel = SEL_FEAT;
            16'h0803: sel = SEL_STAT;
            16'h0808: sel = SEL_LAMP;
            16'h080C: sel = SEL_EQUIP;
            16'h0810: sel = SEL_NVL1;
            16'h0812: sel = SEL_NVL2;
            16'h0814: sel = SEL_CINV;
            16'h0818: sel = SEL_KEY;
            16'h081C: sel = SEL_SYSCTL;
            16'h0823: sel = SEL_CACHE;
            16'h0850: sel = SEL_MAP;
            default:  sel = SEL_NONE;
        endcase
    end

    always_comb begin
        case (sel)
            SEL_P92, SEL_CPUCFG, SEL_FEAT, SEL_STAT, SEL_LAMP, SEL_NVL1,
            SEL_NVL2, SEL_CINV, SEL_SYSCTL, SEL_MAP: wr_ok = 1'b1;
            default:                                 wr_ok = 1'b0;
        endcase
    end
endmodule

// File: rtl/sysctl_rdmux.sv
module sysctl_rdmux
    import sysctl_pkg::*;
(
    input  sel_e              sel,
    input  logic [CTRL_W-1:0] sysctl,
    input  logic              map,
    output logic [DATA_W-1:0] rdata
);
    always_comb begin
        rdata = RD_UNMAPPED;
        case (sel)
            SEL_P92:    rdata = '0;
            SEL_CPUCFG: rdata = ID_CPUCFG;
            SEL_FEAT:   rdata = ID_FEAT;
            SEL_STAT:   rdata = ID_STAT;
            SEL_EQUIP:  rdata = ID_EQUIP;
            SEL_NVL1:   rdata = ID_EXTFEAT;
            SEL_KEY:    rdata = '0;
            SEL_SYSCTL: rdata = DATA_W'(sysctl);
            SEL_CACHE:  rdata = ID_CACHE;
            SEL_MAP:    rdata = DATA_W'(map);
            default:    rdata = RD_UNMAPPED;
        endcase
    end
endmodule

// File: rtl/sysctl_ports.sv
module sysctl_ports
    import sysctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_rd,
    input  logic              io_wr,
    input  logic [DATA_W-1:0] io_wdata,
    output logic [DATA_W-1:0] io_rdata,
    output logic              soft_rst,
    output logic              le_mode,
    output logic              disk_lamp,
    output logic              nvl1_pulse,
    output logic              nvl2_pulse,
    output logic [CTRL_W-1:0] sys_ctrl,
    output logic              map_mode,
    output logic              wr_err
);
    state_t            st_d, st_q;
    sel_e              sel;
    logic              wr_ok;
    logic [DATA_W-1:0] rd_val;

    sysctl_decode u_dec (.addr(io_addr), .sel(sel), .wr_ok(wr_ok));

    sysctl_rdmux u_mux (
        .sel(sel), .sysctl(st_q.sysctl), .map(st_q.map), .rdata(rd_val)
    );

    always_comb begin
        st_d      = st_q;
        st_d.nvl1 = 1'b0;
        st_d.nvl2 = 1'b0;
        if (io_rd) st_d.rdata = rd_val;
        if (io_wr) begin
            if (!wr_ok) st_d.err = 1'b1;
            case (sel)
                SEL_P92: begin
                    st_d.soft_rst = io_wdata[0];
                    st_d.le_mode  = io_wdata[1];
                end
                SEL_LAMP:   st_d.lamp   = io_wdata[0];
                SEL_NVL1:   st_d.nvl1   = 1'b1;
                SEL_NVL2:   st_d.nvl2   = 1'b1;
                SEL_SYSCTL: st_d.sysctl = io_wdata[CTRL_W-1:0];
                SEL_MAP:    st_d.map    = io_wdata[0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign io_rdata   = st_q.rdata;
    assign soft_rst   = st_q.soft_rst;
    assign le_mode    = st_q.le_mode;
    assign disk_lamp  = st_q.lamp;
    assign nvl1_pulse = st_q.nvl1;
    assign nvl2_pulse = st_q.nvl2;
    assign sys_ctrl   = st_q.sysctl;
    assign map_mode   = st_q.map;
    assign wr_err     = st_q.err;
endmodule

// File: rtl/sysctl_ports_chk.sv
module sysctl_ports_chk
    import sysctl_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] io_addr,
    input logic              io_rd,
    input logic              io_wr,
    input logic [DATA_W-1:0] io_rdata,
    input logic              nvl1_pulse,
    input logic              nvl2_pulse,
    input logic [CTRL_W-1:0] sys_ctrl,
    input logic              wr_err
);
    logic past_ok;
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    AST_NVL1_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> (nvl1_pulse == $past(io_wr && io_addr == 16'h0810))); // R6
    AST_NVL2_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> (nvl2_pulse == $past(io_wr && io_addr == 16'h0812))); // R6
    AST_SYSCTL_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !$stable(sys_ctrl)) |-> $past(io_wr && io_addr == 16'h081C)); // R7
    AST_P92_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(io_rd && io_addr == 16'h0092)) |-> io_rdata == 8'h00); // R2
    AST_CPUCFG_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(io_rd && io_addr == 16'h0800)) |-> io_rdata == 8'hEF); // R3
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(wr_err)) |-> wr_err); // R11
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !$past(io_rd)) |-> $stable(io_rdata)); // R12
endmodule

bind sysctl_ports sysctl_ports_chk u_chk (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
    .io_rdata(io_rdata), .nvl1_pulse(nvl1_pulse), .nvl2_pulse(nvl2_pulse),
    .sys_ctrl(sys_ctrl), .wr_err(wr_err)
);

// File: tb/sim_sysctl_ports.sv
module sim_sysctl_ports;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] io_addr = '0;
    logic        io_rd = 1'b0, io_wr = 1'b0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata;
    logic        soft_rst, le_mode, disk_lamp, nvl1_pulse, nvl2_pulse, map_mode, wr_err;
    logic [3:0]  sys_ctrl;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    logic       m_srst, m_le, m_lamp, m_p1, m_p2, m_map, m_err;
    logic [3:0] m_ctl;
    logic [7:0] m_rd;

    always #2 clk = ~clk;

    sysctl_ports u0 (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .soft_rst(soft_rst), .le_mode(le_mode),
        .disk_lamp(disk_lamp), .nvl1_pulse(nvl1_pulse), .nvl2_pulse(nvl2_pulse),
        .sys_ctrl(sys_ctrl), .map_mode(map_mode), .wr_err(wr_err)
    );

    function automatic logic [7:0] exp_read(input logic [15:0] a);
        case (a)
            16'h0092: return 8'h00;
            16'h0800: return 8'hEF;
            16'h0802: return 8'hAD;
            16'h0803: return 8'hE0;
            16'h080C: return 8'h3C;
            16'h0810: return 8'h39;
            16'h0818: return 8'h00;
            16'h081C: return {4'h0, m_ctl};
            16'h0823: return 8'h03;
            16'h0850: return {7'h0, m_map};
            default:  return 8'hFF;
        endcase
    endfunction

    function automatic bit accepted(input logic [15:0] a);
        case (a)
            16'h0092, 16'h0800, 16'h0802, 16'h0803, 16'h0808, 16'h0810,
            16'h0812, 16'h0814, 16'h081C, 16'h0850: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h @%0t", req, act, exp, $time);
        end
    endtask

    task automatic check_all(input string req);
        chk(io_rdata == m_rd,     {req, " rdata"}, io_rdata, m_rd);
        chk(soft_rst == m_srst,   {req, " soft_rst"}, soft_rst, m_srst);
        chk(le_mode == m_le,      {req, " le_mode"}, le_mode, m_le);
        chk(disk_lamp == m_lamp,  {req, " lamp"}, disk_lamp, m_lamp);
        chk(nvl1_pulse == m_p1,   {req, " nvl1"}, nvl1_pulse, m_p1);
        chk(nvl2_pulse == m_p2,   {req, " nvl2"}, nvl2_pulse, m_p2);
        chk(sys_ctrl == m_ctl,    {req, " sys_ctrl"}, sys_ctrl, m_ctl);
        chk(map_mode == m_map,    {req, " map"}, map_mode, m_map);
        chk(wr_err == m_err,      {req, " err"}, wr_err, m_err);
    endtask

    // one access at a negedge, outputs compared at the following negedge
    task automatic step(input bit w, input bit r, input logic [15:0] a, input logic [7:0] d,
                        input string req);
        io_wr = w; io_rd = r; io_addr = a; io_wdata = d;
        if (r) m_rd = exp_read(a);
        m_p1 = w && a == 16'h0810;
        m_p2 = w && a == 16'h0812;
        if (w) begin
            if (!accepted(a)) m_err = 1'b1;
            case (a)
                16'h0092: begin m_srst = d[0]; m_le = d[1]; end
                16'h0808: m_lamp = d[0];
                16'h081C: m_ctl = d[3:0];
                16'h0850: m_map = d[0];
                default: ;
            endcase
        end
        @(posedge clk); @(negedge clk);
        io_wr = 1'b0; io_rd = 1'b0;
        check_all(req);
    endtask

    initial begin
        #400000;
        n_fail++;
        $display("FAIL watchdog expired");
        if (!done) $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
        $finish;
    end

    initial begin
        logic [15:0] pool [0:15];
        void'($urandom(32'h1F2E3D4C));
        {m_srst, m_le, m_lamp, m_p1, m_p2, m_map, m_err} = '0;
        m_ctl = '0; m_rd = '0;
        repeat (3) @(negedge clk);
        check_all("R1 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1 after reset");

        step(0, 1, 16'h0092, 0, "R2 read 92");
        step(1, 0, 16'h0092, 8'h03, "R2 write 92=3");
        step(1, 1, 16'h0092, 8'hFE, "R2 write 92=FE");
        step(0, 1, 16'h0800, 0, "R3 read 800");
        step(0, 1, 16'h0802, 0, "R3 read 802");
        step(0, 1, 16'h0803, 0, "R3 read 803");
        step(0, 1, 16'h080C, 0, "R3 read 80C");
        step(0, 1, 16'h0810, 0, "R3 read 810");
        step(0, 1, 16'h0823, 0, "R3 read 823");
        step(1, 0, 16'h0800, 8'hFF, "R4 write 800");
        step(1, 0, 16'h0802, 8'h00, "R4 write 802");
        step(1, 0, 16'h0803, 8'h55, "R4 write 803");
        step(0, 1, 16'h0802, 0, "R4 readback 802");
        step(1, 0, 16'h0808, 8'h01, "R5 lamp on");
        step(1, 0, 16'h0808, 8'hFE, "R5 lamp off");
        step(1, 0, 16'h0810, 8'h00, "R6 lock1");
        step(0, 0, 16'h0000, 0, "R6 lock1 ends");
        step(1, 0, 16'h0812, 8'hA5, "R6 lock2");
        step(1, 0, 16'h0812, 8'h00, "R6 lock2 back-to-back");
        step(1, 0, 16'h081C, 8'hF9, "R7 sysctl mask");
        step(0, 1, 16'h081C, 0, "R7 sysctl read");
        step(1, 0, 16'h0850, 8'hFF, "R8 map set");
        step(0, 1, 16'h0850, 0, "R8 map read");
        step(0, 1, 16'h0818, 0, "R9 keylock");
        step(1, 0, 16'h0814, 8'hFF, "R9 cinv write");
        step(0, 1, 16'h0814, 0, "R9 cinv read");
        step(0, 1, 16'h0812, 0, "R9 812 read");
        step(0, 1, 16'h0801, 0, "R10 gap read");
        step(0, 1, 16'h0093, 0, "R10 near 92");
        step(0, 0, 16'h0000, 0, "R12 hold");
        step(1, 0, 16'h080C, 8'hFF, "R11 write ro-id");
        step(1, 0, 16'h0818, 8'h01, "R11 sticky");
        step(0, 1, 16'h0850, 0, "R11 map unchanged");

        pool = '{16'h0092, 16'h0800, 16'h0802, 16'h0803, 16'h0808, 16'h080C,
                 16'h0810, 16'h0812, 16'h0814, 16'h0818, 16'h081C, 16'h0823,
                 16'h0850, 16'h0851, 16'h0809, 16'h0000};
        rst_n = 1'b0;
        @(negedge clk);
        {m_srst, m_le, m_lamp, m_p1, m_p2, m_map, m_err} = '0;
        m_ctl = '0; m_rd = '0;
        check_all("R1 re-reset");
        rst_n = 1'b1;
        for (int i = 0; i < 3000; i++) begin
            logic [15:0] a;
            int op;
            op = $urandom_range(0, 3);
            a  = ($urandom_range(0, 7) == 0) ? 16'($urandom) : pool[$urandom_range(0, 15)];
            step(op == 1 || op == 3, op >= 2, a, 8'($urandom), "R12 random mix");
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule